// File: doc/BRIEF.md
# Display Clock Power Bring-Up and Teardown Sequencer

This block brings the display core clock and the display data buffer up or down as one ordered power sequence. A bring-up command first turns off the reset-handshake enable, because no partner exists to answer that handshake. It then raises a power-domain request for the PLL well and waits for the grant. Next it reads the PLL enable status. If the PLL is already running, the display is taken as already initialised and the sequence ends there. Otherwise the block asks a clock-change sequencer for the maximum core frequency. It then powers the data buffer with a request bit, waits a fixed time and samples the buffer's power state once.

A teardown command runs the reverse order. It drops the buffer power request, waits the same fixed time and samples once. It then asks the clock sequencer for the bypass frequency, which stops the PLL. Last, it releases the power-domain request. Each command ends with a one-cycle `done`. The two timeout flags report a buffer that failed to follow its request, and they hold until the next command is accepted. The fixed wait is counted in pulses of a microsecond tick input.

The states are IDLE, HSK_CLR, DOM_WAIT, PLL_CHECK, CLK_GO, CLK_WAIT, BUF_SET, BUF_WAIT, BUF_CHECK, DOM_DROP and FINISH. The transitions are:
- IDLE→HSK_CLR when a bring-up command is accepted.
- IDLE→BUF_SET when a teardown command is accepted.
- HSK_CLR→DOM_WAIT.
- DOM_WAIT→PLL_CHECK once the request is up and granted.
- PLL_CHECK→FINISH if the PLL is running, PLL_CHECK→CLK_GO otherwise.
- CLK_GO→CLK_WAIT.
- CLK_WAIT→BUF_SET on acknowledge when bringing up, CLK_WAIT→DOM_DROP on acknowledge when tearing down.
- BUF_SET→BUF_WAIT.
- BUF_WAIT→BUF_CHECK when the timer expires.
- BUF_CHECK→FINISH when bringing up, BUF_CHECK→CLK_GO when tearing down.
- DOM_DROP→FINISH.
- FINISH→IDLE.

Top module: `dclk_power_ctrl`

## Requirements
- R1: After reset `rsthsk_en` is 1. `pwr_dom_req`, `clk_req`, `buf_pwr_req`, `busy`, `done`, `err_enable_to` and `err_disable_to` are all 0.
- R2: On bring-up, `rsthsk_en` goes to 0 before `pwr_dom_req` rises. `clk_req` is never raised while `pwr_dom_gnt` is low.
- R3: If `pll_enabled` is 1 when checked during bring-up, the block pulses `done` without raising `clk_req`, leaves `buf_pwr_req` unchanged and keeps `pwr_dom_req` at 1.
- R4: If the PLL is off during bring-up, `clk_req` rises with `clk_freq_khz` = 624000. Both are held until `clk_ack`. `buf_pwr_req` rises only after that acknowledge.
- R5: After bring-up sets `buf_pwr_req`, the block waits WAIT_US tick pulses and then samples `buf_pwr_state` once. `err_enable_to` is set if the sample is 0.
- R6: Teardown first clears `buf_pwr_req`, waits WAIT_US tick pulses and samples once. `err_disable_to` is set if `buf_pwr_state` is still 1. No `clk_req` is raised while `buf_pwr_req` is 1.
- R7: After the teardown buffer step, `clk_req` rises with `clk_freq_khz` = 19200. After its acknowledge, `pwr_dom_req` drops, and then `done` pulses.
- R8: A command (`cmd_valid`, with `cmd_init` 1 for bring-up and 0 for teardown) is accepted only while `busy` is 0. `busy` is 1 from acceptance through the single-cycle `done` pulse. A command presented while busy has no effect.
- R9: Both timeout flags hold their value until the next command is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_init | input | 1 | 1 = bring-up, 0 = teardown |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_enable_to | output | 1 | Buffer failed to power up (sticky) |
| err_disable_to | output | 1 | Buffer failed to power down (sticky) |
| rsthsk_en | output | 1 | Reset-handshake enable, reset value 1 |
| pwr_dom_req | output | 1 | PLL power-domain request |
| pwr_dom_gnt | input | 1 | PLL power-domain grant |
| pll_enabled | input | 1 | PLL enable status |
| clk_req | output | 1 | Clock-change request, held until acknowledge |
| clk_freq_khz | output | FREQ_W | Requested core frequency in kHz |
| clk_ack | input | 1 | Clock-change acknowledge |
| buf_pwr_req | output | 1 | Data-buffer power request |
| buf_pwr_state | input | 1 | Data-buffer power state |

## Verification
Counted from the edge that accepts a command, `busy` is visible in the next cycle. `rsthsk_en` falls one edge later, and `pwr_dom_req` rises the edge after that. The buffer result is due WAIT_US tick pulses plus about two cycles after the buffer request changes. The bench therefore sweeps the delay of its buffer model in whole ticks, away from the exact threshold, and expects a timeout only when the delay exceeds WAIT_US ticks. Every other result is read at falling edges: order-of-event flags collected during the command, and port values one cycle after `done`, when `done` and `busy` must both be low.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HSK_CLR,
        ST_DOM_WAIT,
        ST_PLL_CHECK,
        ST_CLK_GO,
        ST_CLK_WAIT,
        ST_BUF_SET,
        ST_BUF_WAIT,
        ST_BUF_CHECK,
        ST_DOM_DROP,
        ST_FINISH
    } dclk_state_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dclk_dir_e;

endpackage

// File: rtl/dclk_us_timer.sv
module dclk_us_timer #(
    parameter int WAIT_US = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(WAIT_US + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_US);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q && tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == LIMIT);

    AST_EXPIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick)); // R5

endmodule

// File: rtl/dclk_freq_hs.sv
module dclk_freq_hs #(
    parameter int FREQ_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic              ack,
    output logic              req,
    output logic [FREQ_W-1:0] freq,
    output logic              fin
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req  <= 1'b0;
            freq <= '0;
        end else if (go) begin
            req  <= 1'b1;
            freq <= freq_in;
        end else if (req && ack) begin
            req  <= 1'b0;
        end
    end

    assign fin = req && ack;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !go) |=> (req && $stable(freq))); // R4

endmodule

// File: rtl/dclk_power_ctrl.sv
module dclk_power_ctrl
    import dclk_pkg::*;
#(
    parameter int WAIT_US         = 10,
    parameter int FREQ_W          = 20,
    parameter int FREQ_MAX_KHZ    = 624000,
    parameter int FREQ_BYPASS_KHZ = 19200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cmd_valid,
    input  logic              cmd_init,
    output logic              busy,
    output logic              done,
    output logic              err_enable_to,
    output logic              err_disable_to,
    output logic              rsthsk_en,
    output logic              pwr_dom_req,
    input  logic              pwr_dom_gnt,
    input  logic              pll_enabled,
    output logic              clk_req,
    output logic [FREQ_W-1:0] clk_freq_khz,
    input  logic              clk_ack,
    output logic              buf_pwr_req,
    input  logic              buf_pwr_state
);
    localparam logic [FREQ_W-1:0] F_MAX    = FREQ_W'(FREQ_MAX_KHZ);
    localparam logic [FREQ_W-1:0] F_BYPASS = FREQ_W'(FREQ_BYPASS_KHZ);

    dclk_state_e state_q, state_d;
    dclk_dir_e   dir_q;
    logic        hsk_q, dom_q, buf_q, err_en_q, err_dis_q;
    logic        accept, going_up;
    logic        clk_go, clk_fin, tmr_start, tmr_exp;

    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign going_up = (dir_q == DIR_UP);
    assign clk_go    = (state_q == ST_CLK_GO);
    assign tmr_start = (state_q == ST_BUF_SET);

    dclk_us_timer #(.WAIT_US(WAIT_US)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .tick    (us_tick),
        .expired (tmr_exp)
    );

    dclk_freq_hs #(.FREQ_W(FREQ_W)) u_freq_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (clk_go),
        .freq_in (going_up ? F_MAX : F_BYPASS),
        .ack     (clk_ack),
        .req     (clk_req),
        .freq    (clk_freq_khz),
        .fin     (clk_fin)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cmd_valid) state_d = cmd_init ? ST_HSK_CLR : ST_BUF_SET;
            ST_HSK_CLR:   state_d = ST_DOM_WAIT;
            ST_DOM_WAIT:  if (dom_q && pwr_dom_gnt) state_d = ST_PLL_CHECK;
            ST_PLL_CHECK: state_d = pll_enabled ? ST_FINISH : ST_CLK_GO;
            ST_CLK_GO:    state_d = ST_CLK_WAIT;
            ST_CLK_WAIT:  if (clk_fin) state_d = going_up ? ST_BUF_SET : ST_DOM_DROP;
            ST_BUF_SET:   state_d = ST_BUF_WAIT;
            ST_BUF_WAIT:  if (tmr_exp) state_d = ST_BUF_CHECK;
            ST_BUF_CHECK: state_d = going_up ? ST_FINISH : ST_CLK_GO;
            ST_DOM_DROP:  state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= DIR_UP;
            hsk_q     <= 1'b1;
            dom_q     <= 1'b0;
            buf_q     <= 1'b0;
            err_en_q  <= 1'b0;
            err_dis_q <= 1'b0;
        end else begin
            if (accept) begin
                dir_q     <= cmd_init ? DIR_UP : DIR_DOWN;
                err_en_q  <= 1'b0;
                err_dis_q <= 1'b0;
            end
            unique case (state_q)
                ST_HSK_CLR:   hsk_q <= 1'b0;
                ST_DOM_WAIT:  dom_q <= 1'b1;
                ST_BUF_SET:   buf_q <= going_up;
                ST_BUF_CHECK: begin
                    if (going_up && !buf_pwr_state)  err_en_q  <= 1'b1;
                    if (!going_up && buf_pwr_state)  err_dis_q <= 1'b1;
                end
                ST_DOM_DROP:  dom_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign done           = (state_q == ST_FINISH);
    assign rsthsk_en      = hsk_q;
    assign pwr_dom_req    = dom_q;
    assign buf_pwr_req    = buf_q;
    assign err_enable_to  = err_en_q;
    assign err_disable_to = err_dis_q;

    AST_HSK_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dom_req) |-> !rsthsk_en); // R2
    AST_CLK_UNDER_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_req) |-> pwr_dom_req); // R2
    AST_BUF_UP_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_pwr_req) |-> !clk_req); // R4
    AST_CLK_NOT_WITH_BUF_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_req) && (clk_freq_khz == F_BYPASS)) |-> !buf_pwr_req); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(buf_pwr_req) && $stable(pwr_dom_req) && !clk_req)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_enable_to && !accept) |=> err_enable_to); // R9

endmodule

// File: tb/tb_dclk_power_ctrl.sv
module tb_dclk_power_ctrl;
    localparam int CLK_P    = 10;
    localparam int WAIT     = 10;
    localparam int TICK_DIV = 4;
    localparam int GNT_DLY  = 3;
    localparam int ACK_DLY  = 5;
    localparam int FW       = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_init = 1'b0;
    logic busy, done, err_enable_to, err_disable_to, rsthsk_en;
    logic pwr_dom_req, clk_req, buf_pwr_req;
    logic pwr_dom_gnt = 1'b0;
    logic pll_enabled = 1'b0;
    logic clk_ack = 1'b0;
    logic buf_pwr_state = 1'b0;
    logic [FW-1:0] clk_freq_khz;

    dclk_power_ctrl #(.WAIT_US(WAIT), .FREQ_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .cmd_valid(cmd_valid), .cmd_init(cmd_init),
        .busy(busy), .done(done),
        .err_enable_to(err_enable_to), .err_disable_to(err_disable_to),
        .rsthsk_en(rsthsk_en), .pwr_dom_req(pwr_dom_req), .pwr_dom_gnt(pwr_dom_gnt),
        .pll_enabled(pll_enabled), .clk_req(clk_req), .clk_freq_khz(clk_freq_khz),
        .clk_ack(clk_ack), .buf_pwr_req(buf_pwr_req), .buf_pwr_state(buf_pwr_state)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Environment models and event monitor, all at the falling edge
    int tick_ph = 0;
    int buf_d = 0;
    int buf_cnt = 0;
    int ack_cnt = 0;
    logic [7:0] gsh = '0;
    bit saw_clk, bad_order, bad_buf, bad_down, saw_ack, prev_dom, prev_buf;
    int hsk_at_dom, last_freq, done_cnt;

    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % TICK_DIV;
        us_tick = (tick_ph == 0);
        gsh = {gsh[6:0], pwr_dom_req};
        pwr_dom_gnt = gsh[GNT_DLY-1];
        if (clk_ack) clk_ack = 1'b0;
        else if (clk_req) begin
            ack_cnt++;
            if (ack_cnt >= ACK_DLY) begin
                clk_ack = 1'b1;
                saw_ack = 1'b1;
                pll_enabled = (clk_freq_khz != FW'(19200));
                ack_cnt = 0;
            end
        end
        if (buf_pwr_state != buf_pwr_req) begin
            if (us_tick) buf_cnt++;
            if (buf_cnt >= buf_d) begin
                buf_pwr_state = buf_pwr_req;
                buf_cnt = 0;
            end
        end else buf_cnt = 0;
        if (clk_req) begin
            saw_clk = 1'b1;
            last_freq = int'(clk_freq_khz);
            if (!pwr_dom_gnt) bad_order = 1'b1;
            if (buf_pwr_req && clk_freq_khz == FW'(19200)) bad_down = 1'b1;
        end
        if (pwr_dom_req && !prev_dom) hsk_at_dom = int'(rsthsk_en);
        if (buf_pwr_req && !prev_buf && !saw_ack) bad_buf = 1'b1;
        prev_dom = pwr_dom_req;
        prev_buf = buf_pwr_req;
        if (done) done_cnt++;
    end

    task automatic clear_mon();
        saw_clk = 0; bad_order = 0; bad_buf = 0; bad_down = 0; saw_ack = 0;
        hsk_at_dom = -1; last_freq = -1; done_cnt = 0;
    endtask

    // Issue a command; optionally present a second command while busy
    task automatic run_cmd(input bit up, input bit spurious);
        int cyc;
        clear_mon();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_init = up;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        chk(!err_enable_to && !err_disable_to, "R9 flags cleared on accept",
            int'({err_enable_to, err_disable_to}), 0);
        if (spurious) begin
            repeat (4) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_init = ~up;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R8 done reached", int'(done), 1);
        @(negedge clk);
        #1;
        chk(!done && !busy, "R8 done single pulse then idle", int'({done, busy}), 0);
    endtask

    task automatic settle_buf();
        for (int i = 0; i < 400 && buf_pwr_state != buf_pwr_req; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        chk(rsthsk_en == 1'b1, "R1 handshake enable at reset", int'(rsthsk_en), 1);
        chk(!pwr_dom_req && !clk_req && !buf_pwr_req, "R1 requests low",
            int'({pwr_dom_req, clk_req, buf_pwr_req}), 0);
        chk(!busy && !done && !err_enable_to && !err_disable_to, "R1 status low",
            int'({busy, done, err_enable_to, err_disable_to}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Bring-up with PLL off
        buf_d = 2;
        run_cmd(1'b1, 1'b0);
        chk(hsk_at_dom == 0, "R2 handshake cleared before domain request", hsk_at_dom, 0);
        chk(!bad_order, "R2 clock request only after grant", int'(bad_order), 0);
        chk(saw_clk && last_freq == 624000, "R4 maximum frequency requested", last_freq, 624000);
        chk(!bad_buf, "R4 buffer request after clock acknowledge", int'(bad_buf), 0);
        chk(buf_pwr_req && pwr_dom_req, "R5 buffer and domain requested",
            int'({buf_pwr_req, pwr_dom_req}), 3);
        chk(!err_enable_to, "R5 no enable timeout", int'(err_enable_to), 0);
        settle_buf();

        // Teardown with a stray command while busy
        run_cmd(1'b0, 1'b1);
        chk(done_cnt == 1, "R8 stray command ignored", done_cnt, 1);
        chk(!buf_pwr_req, "R6 buffer request cleared", int'(buf_pwr_req), 0);
        chk(!bad_down, "R6 no clock request while buffer requested", int'(bad_down), 0);
        chk(last_freq == 19200, "R7 bypass frequency requested", last_freq, 19200);
        chk(!pwr_dom_req, "R7 domain released", int'(pwr_dom_req), 0);
        chk(!pll_enabled, "R7 PLL stopped", int'(pll_enabled), 0);
        settle_buf();

        // Bring-up with PLL already running
        pll_enabled = 1'b1;
        run_cmd(1'b1, 1'b0);
        chk(!saw_clk, "R3 no clock request", int'(saw_clk), 0);
        chk(!buf_pwr_req, "R3 buffer untouched", int'(buf_pwr_req), 0);
        chk(pwr_dom_req, "R3 domain kept", int'(pwr_dom_req), 1);
        chk(!err_enable_to, "R3 no error", int'(err_enable_to), 0);
        pll_enabled = 1'b0;
        run_cmd(1'b0, 1'b0);
        settle_buf();

        // Sweep of buffer response delay in ticks
        for (int d = 0; d <= WAIT + 4; d++) begin
            if (d == WAIT) continue;
            buf_d = d;
            run_cmd(1'b1, 1'b0);
            chk(err_enable_to == (d > WAIT), "R5 enable timeout vs delay",
                int'(err_enable_to), int'(d > WAIT));
            settle_buf();
            run_cmd(1'b0, 1'b0);
            chk(err_disable_to == (d > WAIT), "R6 disable timeout vs delay",
                int'(err_disable_to), int'(d > WAIT));
            repeat (3) @(negedge clk);
            chk(err_disable_to == (d > WAIT), "R9 flag holds while idle",
                int'(err_disable_to), int'(d > WAIT));
            settle_buf();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule